// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block produces the two early-warning flags of a FIFO buffer. It holds two threshold registers, one that sets how few stored words count as "almost empty" and one that sets how little free room counts as "almost full". It compares these thresholds with the word counts it is given for each side. The FIFO storage and the pointer logic sit outside the block. Each count input arrives already synchronised to the clock of the side that uses it.

On a master reset a strap input chooses one of two built-in threshold values, and both registers take that value. After reset, either threshold can be rewritten. One way is a serial bit stream clocked in on the write clock. The other is a parallel write from the data bus, which fills the empty threshold first and the full threshold next. A partial reset clears the flags and restarts the loading sequence but keeps the programmed thresholds. The almost-full flag is a register in the write clock domain. The almost-empty flag is a register in the read clock domain. Both flags are active low.

Top module: `fifo_prog_flags`

## Requirements
- R1: A master reset with `dflt_hi` low sets both thresholds to 0x07F.
- R2: A master reset with `dflt_hi` high sets both thresholds to 0x3FF.
- R3: Each `wclk` cycle with `ser_en` high and `par_ld` low stores one `ser_in` bit. The first ADDR_W bits go to the empty threshold, LSB first. The next ADDR_W bits go to the full threshold, LSB first. The sequence then wraps back to the empty threshold.
- R4: Each `wclk` cycle with `par_ld` high writes `din[ADDR_W-1:0]` into one threshold. The writes alternate, empty threshold first and full threshold second. When `par_ld` is high, `ser_en` has no effect in that cycle.
- R5: A partial reset leaves both thresholds unchanged. It sends both the serial sequence and the parallel sequence back to the empty threshold.
- R6: One `rclk` edge after `rd_cnt` is sampled, `almost_empty_n` is 0 when `rd_cnt` <= empty threshold and 1 otherwise.
- R7: One `wclk` edge after `wr_cnt` is sampled, `almost_full_n` is 0 when 2^ADDR_W - `wr_cnt` <= full threshold and 1 otherwise.
- R8: In a cycle where either reset is sampled high, the flags go to `almost_empty_n`=0 and `almost_full_n`=1, whatever the counts are.
- R9: Data bits `din[DATA_W-1:ADDR_W]` are ignored by parallel loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock; clocks the thresholds and the almost-full flag |
| rclk | input | 1 | Read-side clock; clocks the almost-empty flag |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high; thresholds are kept |
| dflt_hi | input | 1 | Strap sampled during master reset: 0 selects 0x07F, 1 selects 0x3FF |
| ser_en | input | 1 | Serial threshold load enable |
| ser_in | input | 1 | Serial threshold data bit |
| par_ld | input | 1 | Parallel threshold load strobe |
| din | input | DATA_W | Data bus; the low ADDR_W bits are used for parallel loads |
| wr_cnt | input | ADDR_W+1 | Stored word count as seen from the write side |
| rd_cnt | input | ADDR_W+1 | Stored word count as seen from the read side |
| almost_full_n | output | 1 | Almost-full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The thresholds can only be seen through the flags. A wrong threshold bit therefore shows up as a flag that switches at a different count, and it is visible one clock after a count at or next to the boundary is applied. For this reason every threshold load is checked by probing the count equal to the threshold and the count one above it, on both flags. Randomised counts then compare flag values against the expected thresholds. If the load sequence is corrupted, for example bits land in the wrong register or the sequence does not restart after a partial reset, then one of these boundary probes gives the wrong flag level in the very next cycle.

// File: rtl/fifo_prog_flags.sv
module fifo_prog_flags #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 18,
  parameter logic [ADDR_W-1:0] OFF_LO = 'h07F,
  parameter logic [ADDR_W-1:0] OFF_HI = 'h3FF
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              dflt_hi,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic              par_ld,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   wr_cnt,
  input  logic [ADDR_W:0]   rd_cnt,
  output logic              almost_full_n,
  output logic              almost_empty_n
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int SP_W  = $clog2(2 * ADDR_W);
  localparam int IDX_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;
  localparam logic [SP_W-1:0]  SP_MID = SP_W'(ADDR_W);
  localparam logic [SP_W-1:0]  SP_LAST = SP_W'(2 * ADDR_W - 1);

  logic [ADDR_W-1:0] e_off, f_off;
  logic [SP_W-1:0]   ser_pos;
  logic              par_sel;

  wire              ser_hi = (ser_pos >= SP_MID);
  wire [SP_W-1:0]   ser_rel = ser_hi ? ser_pos - SP_MID : ser_pos;
  wire [IDX_W-1:0]  ser_idx = ser_rel[IDX_W-1:0];
  wire [CNT_W-1:0]  free_w = DEPTH - wr_cnt;

  always_ff @(posedge wclk) begin
    if (mrst) begin
      e_off   <= dflt_hi ? OFF_HI : OFF_LO;
      f_off   <= dflt_hi ? OFF_HI : OFF_LO;
      ser_pos <= '0;
      par_sel <= 1'b0;
    end else if (prst) begin
      ser_pos <= '0;
      par_sel <= 1'b0;
    end else if (par_ld) begin
      if (par_sel) f_off <= din[ADDR_W-1:0];
      else         e_off <= din[ADDR_W-1:0];
      par_sel <= ~par_sel;
    end else if (ser_en) begin
      if (ser_hi) f_off[ser_idx] <= ser_in;
      else        e_off[ser_idx] <= ser_in;
      ser_pos <= (ser_pos == SP_LAST) ? '0 : ser_pos + SP_W'(1);
    end
  end

  always_ff @(posedge wclk) begin
    if (mrst || prst) almost_full_n <= 1'b1;
    else              almost_full_n <= free_w > {1'b0, f_off};
  end

  always_ff @(posedge rclk) begin
    if (mrst || prst) almost_empty_n <= 1'b0;
    else              almost_empty_n <= rd_cnt > {1'b0, e_off};
  end
endmodule

// File: rtl/fifo_prog_flags_chk.sv
module fifo_prog_flags_chk #(
  parameter int ADDR_W = 14
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              prst,
  input logic              ser_en,
  input logic              par_ld,
  input logic [ADDR_W:0]   wr_cnt,
  input logic [ADDR_W:0]   rd_cnt,
  input logic [ADDR_W-1:0] e_off,
  input logic [ADDR_W-1:0] f_off,
  input logic              almost_full_n,
  input logic              almost_empty_n
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

  logic w_seen, r_seen;
  always_ff @(posedge wclk) if (mrst) w_seen <= 1'b1;
  always_ff @(posedge rclk) if (mrst) r_seen <= 1'b1;

  // R6
  ae_thr_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (r_seen && !$past(mrst || prst)) |->
      (almost_empty_n == ($past(rd_cnt) > {1'b0, $past(e_off)})));

  // R7
  af_thr_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    (w_seen && !$past(mrst || prst)) |->
      (almost_full_n == ((DEPTH - $past(wr_cnt)) > {1'b0, $past(f_off)})));

  // R5
  offs_hold_chk: assert property (@(posedge wclk) disable iff (mrst)
    (w_seen && !ser_en && !par_ld) |=> ($stable(e_off) && $stable(f_off)));

  // R4
  one_offs_chk: assert property (@(posedge wclk) disable iff (mrst)
    w_seen |=> ($stable(e_off) || $stable(f_off)));
endmodule

bind fifo_prog_flags fifo_prog_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
  .ser_en(ser_en), .par_ld(par_ld), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
  .e_off(e_off), .f_off(f_off),
  .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
);

// File: tb/tb_fifo_prog_flags.sv
module tb_fifo_prog_flags;
  localparam int AW = 14;
  localparam int DW = 18;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH = CW'(1) << AW;

  logic clk = 1'b0;
  logic mrst, prst, dflt_hi, ser_en, ser_in, par_ld;
  logic [DW-1:0] din;
  logic [CW-1:0] wr_cnt, rd_cnt;
  logic almost_full_n, almost_empty_n;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  fifo_prog_flags #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .dflt_hi(dflt_hi),
    .ser_en(ser_en), .ser_in(ser_in), .par_ld(par_ld), .din(din),
    .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
  );

  function automatic logic exp_ae(input logic [CW-1:0] c, input logic [AW-1:0] e);
    return c > {1'b0, e};
  endfunction

  function automatic logic exp_af(input logic [CW-1:0] c, input logic [AW-1:0] f);
    return (DEPTH - c) > {1'b0, f};
  endfunction

  task automatic cmp(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [CW-1:0] rc, input logic [CW-1:0] wc,
                       input logic [AW-1:0] e, input logic [AW-1:0] f, input string tag);
    rd_cnt = rc; wr_cnt = wc;
    @(posedge clk); @(negedge clk);
    cmp(almost_empty_n, exp_ae(rc, e), tag);
    cmp(almost_full_n, exp_af(wc, f), tag);
  endtask

  task automatic probe(input logic [AW-1:0] e, input logic [AW-1:0] f, input string tag);
    apply(CW'(e), DEPTH - CW'(f), e, f, tag);
    apply(CW'(e) + 1'b1, DEPTH - CW'(f) - 1'b1, e, f, tag);
  endtask

  task automatic master_reset(input logic hi);
    dflt_hi = hi; mrst = 1'b1;
    @(posedge clk); @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic par_write(input logic [AW-1:0] v);
    din = {$urandom_range(15, 1), v} ;
    par_ld = 1'b1; ser_en = 1'b1; ser_in = 1'b1;
    @(posedge clk); @(negedge clk);
    par_ld = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] se, sf, pa, pb, pc;
    void'($urandom(32'd7731));
    mrst = 1'b1; prst = 1'b0; dflt_hi = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
    par_ld = 1'b0; din = '0; rd_cnt = CW'(500); wr_cnt = DEPTH;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R8: reset overrides counts that would give the opposite levels
    cmp(almost_empty_n, 1'b0, "R8 mrst ae");
    cmp(almost_full_n, 1'b1, "R8 mrst af");
    mrst = 1'b0;

    // R1
    probe(AW'('h07F), AW'('h07F), "R1 default low");
    // R2
    master_reset(1'b1);
    probe(AW'('h3FF), AW'('h3FF), "R2 default high");

    // R3 serial load
    se = AW'($urandom); sf = AW'($urandom);
    for (int i = 0; i < 2 * AW; i++) begin
      ser_en = 1'b1;
      ser_in = (i < AW) ? se[i] : sf[i - AW];
      @(posedge clk); @(negedge clk);
    end
    ser_en = 1'b0;
    probe(se, sf, "R3 serial load");

    // R4 R9 parallel load, serial enable held high and ignored
    pa = AW'($urandom); pb = AW'($urandom);
    par_write(pa);
    par_write(pb);
    probe(pa, pb, "R4 R9 parallel load");

    // R5 partial reset keeps values and restarts sequence
    pc = AW'($urandom);
    par_write(pc);
    rd_cnt = DEPTH; wr_cnt = '0;
    prst = 1'b1;
    @(posedge clk); @(negedge clk);
    cmp(almost_empty_n, 1'b0, "R8 prst ae");
    cmp(almost_full_n, 1'b1, "R8 prst af");
    prst = 1'b0;
    probe(pc, pb, "R5 offsets kept");
    par_write(pa);
    probe(pa, pb, "R5 sequence restart");

    // R6 R7 random counts
    for (int k = 0; k < 300; k++) begin
      logic [CW-1:0] rc, wc;
      rc = CW'($urandom_range(int'(DEPTH), 0));
      wc = CW'($urandom_range(int'(DEPTH), 0));
      if (k % 4 == 0) rc = CW'(pa) + CW'($urandom_range(1, 0));
      if (k % 4 == 1) wc = DEPTH - CW'(pb) - CW'($urandom_range(1, 0));
      apply(rc, wc, pa, pb, "R6 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule